// File: doc/BRIEF.md
# Control Endpoint SETUP/OUT Responder

This block decides how the control endpoint of a low-speed USB function reacts to SETUP and OUT transactions. An upstream decoder hands it a token strobe with the token kind. It then passes in the bytes of the following data packet (CRC bytes included) and an end strobe that carries the packet's error flag and its PID toggle. The block chooses the handshake (ACK, NAK, STALL or silence). It also decides whether each received byte goes to the endpoint FIFO, whether the toggle and byte count are recorded, and whether the CPU is interrupted.

Three control levels select the response to OUT: a stall level, a status-only level that checks an automatic status stage, and an accept-out level that admits OUT data. These levels are sampled with the token. The block also keeps the endpoint's 8-bit receive status register. The CPU clears this register by writing to it. While a SETUP is flagged in the register, the CPU is kept from overwriting the setup data in the FIFO.

Top module: `cep_responder`

## Requirements
- R1: After a synchronous reset, every output is 0, including the status register, the reply code and the invalid flag.
- R2: A SETUP data packet always writes the FIFO and raises toggle update, count update and interrupt. The reply is ACK (code 1) if the packet is good and none (code 0) if it is bad.
- R3: An OUT taken with accept-out=1, stall=0 and status-only=0 behaves exactly like a SETUP data packet.
- R4: An OUT taken with all three control levels at 0 gets NAK (code 2) if good and none if bad. It causes no FIFO write, no update and no interrupt.
- R5: An OUT taken with stall=1 gets STALL (code 3) if good and none if bad, whatever the other two levels are. It causes no FIFO write, no update and no interrupt.
- R6: An OUT taken with status-only=1 and stall=0 never writes the FIFO. A good DATA1 packet carrying exactly 2 bytes (zero data plus CRC) gets ACK. Any other good packet gets STALL. Both update toggle and count and interrupt. A bad packet updates only the toggle and gets no reply and no interrupt.
- R7: A packet is bad when its error flag is set or it carried more than 10 bytes. The invalid flag is set at the end of a bad packet and cleared at the end of a good one.
- R8: Status bit 0 is set by a SETUP token. Bits 1 and 2 follow every token (1 for OUT, 2 for IN). Bit 3 holds the recorded toggle. Bits 7:4 hold the recorded byte count including CRC, saturating at 15.
- R9: FIFO writes happen only for the first 8 bytes of a packet, at address equal to the byte index, one cycle after the byte strobe.
- R10: A CPU write to the status register clears every bit except bit 3. Bit 0 survives the write while a SETUP data phase is in progress.
- R11: The CPU FIFO write enable equals the CPU request while status bit 0 is 0, and is 0 while it is 1.
- R12: A SETUP token produces a one-cycle pulse on the clear-control output one cycle later.
- R13: Reply, update strobes, interrupt and invalid flag change in the cycle after the end strobe; pulses last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_stb | input | 1 | Token to this endpoint received |
| tok_kind | input | 2 | Token kind: 1 OUT, 2 IN, 3 SETUP |
| rx_byte_stb | input | 1 | One data-packet byte received |
| rx_byte | input | 8 | Received byte value |
| rx_end | input | 1 | Data packet finished |
| rx_bad | input | 1 | CRC, PID or stuffing error on the packet (with rx_end) |
| rx_pid_tgl | input | 1 | Packet PID was DATA1 (with rx_end) |
| ctl_stall | input | 1 | Stall level |
| ctl_status_only | input | 1 | Automatic status-stage level |
| ctl_accept_out | input | 1 | Accept OUT data level |
| cpu_stat_wr | input | 1 | CPU write to the status register |
| cpu_fifo_req | input | 1 | CPU request to write the FIFO |
| fifo_we | output | 1 | FIFO write enable |
| fifo_addr | output | 3 | FIFO write address |
| fifo_wdata | output | 8 | FIFO write data |
| reply | output | 2 | Handshake: 0 none, 1 ACK, 2 NAK, 3 STALL |
| tgl_upd | output | 1 | Toggle recorded |
| cnt_upd | output | 1 | Count recorded |
| irq | output | 1 | Interrupt pulse |
| rx_invalid | output | 1 | Last data packet was bad |
| ctl_clear | output | 1 | Clear stall and IN-enable pulse |
| cpu_fifo_we | output | 1 | Gated CPU FIFO write enable |
| stat | output | 8 | Receive status register |

## Verification
The bench drives SETUP packets longer than eight bytes and longer than fifteen. A design that wrapped the counter, wrote past the FIFO or missed the over-length error would show a wrong count, address or reply. For the status-only mode it sends DATA1 with two bytes, DATA0 with two bytes and DATA1 with four bytes. A status check that ignored the toggle or the length would ACK the wrong one. Stall is raised together with accept-out to expose an inverted precedence. A CPU status write during a SETUP data phase, and another after it, catch a design that drops the SETUP flag early or keeps it too long, which would also wrongly gate CPU FIFO writes.

// File: rtl/cep_pkg.sv
package cep_pkg;
  typedef enum logic [1:0] {TK_NONE = 2'd0, TK_OUT = 2'd1, TK_IN = 2'd2, TK_SETUP = 2'd3} tok_e;
  typedef enum logic [1:0] {RP_NONE = 2'd0, RP_ACK = 2'd1, RP_NAK = 2'd2, RP_STALL = 2'd3} rep_e;

  typedef struct packed {
    logic stall;
    logic stat_only;
    logic acc_out;
  } ctl_t;

  typedef struct packed {
    logic fifo;
    logic tgl;
    logic cnt;
    logic irq;
    rep_e rep;
  } act_t;
endpackage

// File: rtl/cep_counter.sv
module cep_counter #(
  parameter int CNT_W     = 4,
  parameter int MAX_TOTAL = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             stb,
  output logic [CNT_W-1:0] cnt,
  output logic             over
);
  localparam logic [CNT_W-1:0] SAT = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (stb && cnt != SAT) cnt <= cnt + 1'b1;
  end

  assign over = cnt > CNT_W'(MAX_TOTAL);

  // R8
  sat_chk: assert property (@(posedge clk) disable iff (rst)
    (stb && !clr && cnt == SAT) |=> cnt == SAT);
endmodule

// File: rtl/cep_policy.sv
module cep_policy
  import cep_pkg::*;
(
  input  logic is_setup,
  input  ctl_t ctl,
  input  logic good,
  input  logic status_ok,
  output act_t act
);
  always_comb begin
    act = '0;
    act.rep = RP_NONE;
    if (is_setup || (!ctl.stall && !ctl.stat_only && ctl.acc_out)) begin
      act.fifo = 1'b1;
      act.tgl  = 1'b1;
      act.cnt  = 1'b1;
      act.irq  = 1'b1;
      act.rep  = good ? RP_ACK : RP_NONE;
    end else if (ctl.stall) begin
      act.rep = good ? RP_STALL : RP_NONE;
    end else if (ctl.stat_only) begin
      act.tgl = 1'b1;
      if (good) begin
        act.cnt = 1'b1;
        act.irq = 1'b1;
        act.rep = status_ok ? RP_ACK : RP_STALL;
      end
    end else begin
      act.rep = good ? RP_NAK : RP_NONE;
    end
  end
endmodule

// File: rtl/cep_status.sv
module cep_status
  import cep_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_wr,
  input  logic             setup_busy,
  input  logic             tok_stb,
  input  logic [1:0]       tok_kind,
  input  logic             upd_tgl,
  input  logic             tgl_val,
  input  logic             upd_cnt,
  input  logic [CNT_W-1:0] cnt_val,
  output logic [CNT_W+3:0] stat
);
  logic [CNT_W+3:0] nxt;

  always_comb begin
    nxt = stat;
    if (cpu_wr) begin
      nxt = '0;
      nxt[3] = stat[3];
      if (setup_busy) nxt[0] = stat[0];
    end
    if (tok_stb) begin
      if (tok_kind == TK_SETUP) nxt[0] = 1'b1;
      nxt[1] = (tok_kind == TK_OUT);
      nxt[2] = (tok_kind == TK_IN);
    end
    if (upd_tgl) nxt[3] = tgl_val;
    if (upd_cnt) nxt[CNT_W+3:4] = cnt_val;
  end

  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= nxt;
  end

  // R10
  keep_setup_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && setup_busy && stat[0]) |=> stat[0]);
  // R10
  cpu_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !setup_busy && !tok_stb && !upd_cnt) |=> (stat[CNT_W+3:4] == '0 && stat[2:0] == 3'b000));
endmodule

// File: rtl/cep_responder.sv
module cep_responder
  import cep_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int CRC_BYTES = 2,
  parameter int CNT_W     = 4,
  parameter int ADDR_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tok_stb,
  input  logic [1:0]        tok_kind,
  input  logic              rx_byte_stb,
  input  logic [7:0]        rx_byte,
  input  logic              rx_end,
  input  logic              rx_bad,
  input  logic              rx_pid_tgl,
  input  logic              ctl_stall,
  input  logic              ctl_status_only,
  input  logic              ctl_accept_out,
  input  logic              cpu_stat_wr,
  input  logic              cpu_fifo_req,
  output logic              fifo_we,
  output logic [ADDR_W-1:0] fifo_addr,
  output logic [7:0]        fifo_wdata,
  output logic [1:0]        reply,
  output logic              tgl_upd,
  output logic              cnt_upd,
  output logic              irq,
  output logic              rx_invalid,
  output logic              ctl_clear,
  output logic              cpu_fifo_we,
  output logic [CNT_W+3:0]  stat
);
  localparam int MAX_TOTAL = DEPTH + CRC_BYTES;

  logic             in_data, cur_setup;
  ctl_t             ctl_q;
  logic [CNT_W-1:0] cnt;
  logic             over, good, status_ok, end_now, tok_data;
  act_t             act;

  assign tok_data = tok_stb && (tok_kind == TK_SETUP || tok_kind == TK_OUT);
  assign end_now  = rx_end && in_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_data   <= 1'b0;
      cur_setup <= 1'b0;
      ctl_q     <= '0;
    end else if (tok_data) begin
      in_data   <= 1'b1;
      cur_setup <= (tok_kind == TK_SETUP);
      ctl_q     <= '{stall: ctl_stall, stat_only: ctl_status_only, acc_out: ctl_accept_out};
    end else if (end_now) begin
      in_data   <= 1'b0;
    end
  end

  cep_counter #(.CNT_W(CNT_W), .MAX_TOTAL(MAX_TOTAL)) u_cnt (
    .clk(clk), .rst(rst), .clr(tok_data), .stb(rx_byte_stb && in_data),
    .cnt(cnt), .over(over)
  );

  assign good      = !rx_bad && !over;
  assign status_ok = rx_pid_tgl && (cnt == CNT_W'(CRC_BYTES));

  cep_policy u_pol (
    .is_setup(cur_setup), .ctl(ctl_q), .good(good), .status_ok(status_ok), .act(act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_we    <= 1'b0;
      fifo_addr  <= '0;
      fifo_wdata <= '0;
      reply      <= RP_NONE;
      tgl_upd    <= 1'b0;
      cnt_upd    <= 1'b0;
      irq        <= 1'b0;
      rx_invalid <= 1'b0;
      ctl_clear  <= 1'b0;
    end else begin
      fifo_we    <= rx_byte_stb && in_data && act.fifo && (cnt < CNT_W'(DEPTH));
      fifo_addr  <= cnt[ADDR_W-1:0];
      fifo_wdata <= rx_byte;
      reply      <= end_now ? act.rep : RP_NONE;
      tgl_upd    <= end_now && act.tgl;
      cnt_upd    <= end_now && act.cnt;
      irq        <= end_now && act.irq;
      if (end_now) rx_invalid <= !good;
      ctl_clear  <= tok_stb && (tok_kind == TK_SETUP);
    end
  end

  cep_status #(.CNT_W(CNT_W)) u_stat (
    .clk(clk), .rst(rst), .cpu_wr(cpu_stat_wr), .setup_busy(in_data && cur_setup),
    .tok_stb(tok_stb), .tok_kind(tok_kind),
    .upd_tgl(end_now && act.tgl), .tgl_val(rx_pid_tgl),
    .upd_cnt(end_now && act.cnt), .cnt_val(cnt), .stat(stat)
  );

  assign cpu_fifo_we = cpu_fifo_req && !stat[0];

  // R4
  nak_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (reply == RP_NAK) |-> (!irq && !cnt_upd && !tgl_upd && !fifo_we));
  // R6
  cnt_with_tgl_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_upd |-> tgl_upd);
  // R13
  irq_after_end_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(rx_end));
endmodule

// File: tb/cep_responder_tb.sv
module cep_responder_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic tok_stb = 0, rx_byte_stb = 0, rx_end = 0, rx_bad = 0, rx_pid_tgl = 0;
  logic [1:0] tok_kind = 0;
  logic [7:0] rx_byte = 0;
  logic ctl_stall = 0, ctl_status_only = 0, ctl_accept_out = 0;
  logic cpu_stat_wr = 0, cpu_fifo_req = 0;
  logic fifo_we, tgl_upd, cnt_upd, irq, rx_invalid, ctl_clear, cpu_fifo_we;
  logic [2:0] fifo_addr;
  logic [7:0] fifo_wdata, stat;
  logic [1:0] reply;

  cep_responder u_dut (
    .clk(clk), .rst(rst), .tok_stb(tok_stb), .tok_kind(tok_kind),
    .rx_byte_stb(rx_byte_stb), .rx_byte(rx_byte), .rx_end(rx_end), .rx_bad(rx_bad),
    .rx_pid_tgl(rx_pid_tgl), .ctl_stall(ctl_stall), .ctl_status_only(ctl_status_only),
    .ctl_accept_out(ctl_accept_out), .cpu_stat_wr(cpu_stat_wr), .cpu_fifo_req(cpu_fifo_req),
    .fifo_we(fifo_we), .fifo_addr(fifo_addr), .fifo_wdata(fifo_wdata), .reply(reply),
    .tgl_upd(tgl_upd), .cnt_upd(cnt_upd), .irq(irq), .rx_invalid(rx_invalid),
    .ctl_clear(ctl_clear), .cpu_fifo_we(cpu_fifo_we), .stat(stat)
  );

  int checks = 0, errors = 0;
  string cur_req = "R1";

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int nb = 0;
  bit m_in = 0, m_setup = 0, m_st = 0, m_so = 0, m_ao = 0;
  int e_reply = 0, e_addr = 0, e_wd = 0;
  bit e_fw = 0, e_tu = 0, e_cu = 0, e_irq = 0, e_inv = 0, e_clr = 0;
  logic [7:0] e_stat = 0;

  always @(posedge clk) begin
    if (rst) begin
      nb = 0; m_in = 0; m_setup = 0; e_reply = 0; e_fw = 0; e_tu = 0; e_cu = 0;
      e_irq = 0; e_inv = 0; e_clr = 0; e_stat = 0; e_addr = 0; e_wd = 0;
    end else begin
      e_fw = 0; e_reply = 0; e_tu = 0; e_cu = 0; e_irq = 0; e_clr = 0;
      if (cpu_stat_wr) begin
        bit keep0;
        keep0 = (m_in && m_setup) ? e_stat[0] : 1'b0;
        e_stat = {4'b0, e_stat[3], 3'b0};
        e_stat[0] = keep0;
      end
      if (tok_stb) begin
        if (tok_kind == 3) begin e_stat[0] = 1; e_clr = 1; end
        e_stat[1] = (tok_kind == 1);
        e_stat[2] = (tok_kind == 2);
        if (tok_kind == 1 || tok_kind == 3) begin
          m_in = 1; m_setup = (tok_kind == 3); nb = 0;
          m_st = ctl_stall; m_so = ctl_status_only; m_ao = ctl_accept_out;
        end
      end
      if (rx_byte_stb && m_in) begin
        if ((m_setup || (!m_st && !m_so && m_ao)) && nb < 8) begin
          e_fw = 1; e_addr = nb; e_wd = rx_byte;
        end
        if (nb < 15) nb++;
      end
      if (rx_end && m_in) begin
        bit err;
        err = rx_bad || nb > 10;
        e_inv = err;
        if (m_setup || (!m_st && !m_so && m_ao)) begin
          e_tu = 1; e_cu = 1; e_irq = 1; e_reply = err ? 0 : 1;
        end else if (m_st) e_reply = err ? 0 : 3;
        else if (m_so) begin
          e_tu = 1;
          if (!err) begin
            e_cu = 1; e_irq = 1;
            e_reply = (rx_pid_tgl && nb == 2) ? 1 : 3;
          end
        end else e_reply = err ? 0 : 2;
        if (e_tu) e_stat[3] = rx_pid_tgl;
        if (e_cu) e_stat[7:4] = 4'(nb);
        m_in = 0;
      end
    end
  end

  always @(posedge clk) begin
    #2;
    chk(reply == 2'(e_reply), cur_req, "reply", reply, e_reply);
    chk(tgl_upd == e_tu, cur_req, "tgl_upd", tgl_upd, e_tu);
    chk(cnt_upd == e_cu, cur_req, "cnt_upd", cnt_upd, e_cu);
    chk(irq == e_irq, cur_req, "irq", irq, e_irq);
    chk(fifo_we == e_fw, "R9", "fifo_we", fifo_we, e_fw);
    if (e_fw) begin
      chk(fifo_addr == 3'(e_addr), "R9", "fifo_addr", fifo_addr, e_addr);
      chk(fifo_wdata == 8'(e_wd), "R9", "fifo_wdata", fifo_wdata, e_wd);
    end
    chk(stat == e_stat, "R8", "stat", stat, e_stat);
    chk(rx_invalid == e_inv, "R7", "rx_invalid", rx_invalid, e_inv);
    chk(ctl_clear == e_clr, "R12", "ctl_clear", ctl_clear, e_clr);
    chk(cpu_fifo_we == (cpu_fifo_req && !e_stat[0]), "R11", "cpu_fifo_we",
        cpu_fifo_we, int'(cpu_fifo_req && !e_stat[0]));
  end

  // stimulus helpers: enter and leave at a falling edge
  task automatic token(int k);
    tok_stb = 1; tok_kind = 2'(k);
    @(negedge clk); tok_stb = 0; tok_kind = 0;
  endtask

  task automatic packet(int n, bit bad, bit tgl);
    for (int i = 0; i < n; i++) begin
      rx_byte_stb = 1; rx_byte = 8'(8'h40 + i);
      @(negedge clk);
    end
    rx_byte_stb = 0;
    rx_end = 1; rx_bad = bad; rx_pid_tgl = tgl;
    @(negedge clk);
    rx_end = 0; rx_bad = 0; rx_pid_tgl = 0;
  endtask

  task automatic cpu_clear();
    cpu_stat_wr = 1; @(negedge clk); cpu_stat_wr = 0;
  endtask

  task automatic set_ctl(bit s, bit so, bit ao);
    ctl_stall = s; ctl_status_only = so; ctl_accept_out = ao;
  endtask

  bit done = 0;

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(stat == 0 && reply == 0 && !irq && !rx_invalid && !fifo_we, "R1", "reset outputs",
        int'(stat), 0);
    rst = 0;
    @(negedge clk);

    cur_req = "R2";
    token(3); packet(10, 0, 0);
    chk(reply == 2'd1, "R2", "setup good ack", reply, 1);
    cpu_clear();
    token(3); packet(5, 1, 1);
    chk(reply == 2'd0 && irq, "R2", "setup bad silent irq", reply, 0);
    cpu_clear();

    cur_req = "R3";
    set_ctl(0, 0, 1);
    token(1); packet(4, 0, 1);
    token(1); packet(3, 1, 0);

    cur_req = "R4";
    set_ctl(0, 0, 0);
    token(1); packet(6, 0, 0);
    chk(reply == 2'd2, "R4", "nak", reply, 2);
    token(1); packet(6, 1, 0);

    cur_req = "R5";
    set_ctl(1, 0, 1);
    token(1); packet(4, 0, 1);
    chk(reply == 2'd3 && !irq, "R5", "stall", reply, 3);
    token(1); packet(4, 1, 1);
    set_ctl(1, 1, 0);
    token(1); packet(2, 0, 1);

    cur_req = "R6";
    set_ctl(0, 1, 0);
    token(1); packet(2, 0, 1);
    chk(reply == 2'd1, "R6", "status stage ack", reply, 1);
    token(1); packet(2, 0, 0);
    chk(reply == 2'd3, "R6", "data0 status stall", reply, 3);
    token(1); packet(4, 0, 1);
    chk(reply == 2'd3, "R6", "long status stall", reply, 3);
    token(1); packet(2, 1, 1);
    set_ctl(0, 0, 0);

    cur_req = "R7";
    token(3); packet(12, 0, 0);
    chk(rx_invalid == 1 && reply == 2'd0, "R7", "overlong invalid", rx_invalid, 1);
    cpu_clear();
    cur_req = "R8";
    token(3); packet(17, 0, 1);
    chk(stat[7:4] == 4'd15, "R8", "count saturates", stat[7:4], 15);
    token(2);
    chk(stat[2:1] == 2'b10, "R8", "in token bits", stat[2:1], 2);

    cur_req = "R10";
    cpu_clear();
    token(3);
    rx_byte_stb = 1; rx_byte = 8'h11; @(negedge clk); rx_byte_stb = 0;
    cpu_fifo_req = 1;
    cpu_clear();
    chk(stat[0] == 1, "R10", "setup bit kept mid-phase", stat[0], 1);
    chk(cpu_fifo_we == 0, "R11", "cpu fifo blocked", cpu_fifo_we, 0);
    packet(1, 0, 1);
    cpu_clear();
    chk(stat == 8'h08, "R10", "write clears all but bit3", stat, 8);
    chk(cpu_fifo_we == 1, "R11", "cpu fifo allowed", cpu_fifo_we, 1);
    cpu_fifo_req = 0;

    cur_req = "R13";
    set_ctl(0, 0, 1);
    token(1);
    rx_byte_stb = 1; @(negedge clk); rx_byte_stb = 0;
    rx_end = 1; @(negedge clk); rx_end = 0;
    chk(irq == 1, "R13", "irq one cycle after end", irq, 1);
    @(negedge clk);
    chk(irq == 0, "R13", "irq single pulse", irq, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule